// File: doc/BRIEF.md
# UART Sleep and Wake Controller

This block decides when a serial port may drop into a low-power sleep state and when it has to come back. It runs on a free-running clock that is never gated. It watches the receive line, the modem input pins, the emptiness flags of the transmit FIFO, the transmit shift register and the receive FIFO, the pending interrupt sources, and host writes into the transmit FIFO. From these it drives one clock-enable, which the surrounding logic feeds to the gating cells of the module clock and the baud clock. It also drives a sleep status and a sticky wake interrupt.

Sleep is a conjunction. Software must allow it and the enhanced-feature switch must be on. The line must be idle, every buffer must be empty, and no interrupt may be pending except a transmit-holding-empty source. All of these must hold for a short settling window, and a single cycle in which any of them fails restarts the window. Leaving sleep is an event: an edge on the receive line, a change on any modem pin, or a host write into the transmit FIFO. The wake interrupt only records that such an event happened while asleep. It stays set until software drops its enable, and it does not change the interrupt identification code, which lives outside this block.

All control and status pins are plain levels. The only pulse is the write strobe of the transmit FIFO.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: `asleep` can rise only while both `sleep_en` and `enh_en` are 1. With either one at 0, the block stays awake however idle the port is.
- R2: Sleep is entered only while all four of these hold: `rx_line` is high (idle) after synchronization, `tx_fifo_empty` is 1, `tx_shift_empty` is 1 and `rx_fifo_empty` is 1.
- R3: Any set bit of `irq_pending` other than bit index `THR_IDX` (default 1, the transmit-holding-empty source) prevents sleep. Bit `THR_IDX` alone has no effect on entry.
- R4: `clk_gate_en` is 0 exactly while `asleep` is 1, and is 1 from reset onward otherwise.
- R5: Let edge k be the first rising clock edge that samples all entry conditions true. `asleep` rises after edge k+`ENTRY_DLY` (default 4), so the conditions are sampled on `ENTRY_DLY`+1 consecutive edges. An edge that samples any condition false restarts the count.
- R6: A `tx_fifo_wr` pulse sampled while asleep clears `asleep` and raises `clk_gate_en` right after that same edge.
- R7: A change of `rx_line`, or of any bit of `modem_in`, that is set up before edge E ends sleep after edge E+2. This is the two-flop synchronizer plus one edge-detect stage. While awake, such changes have no effect. A modem level alone never blocks entry.
- R8: When `wake_irq_en` is 1, a wake event sampled while asleep sets `wake_irq` after that edge. A wake event while awake does not set it. Once set, `wake_irq` stays 1 for as long as `wake_irq_en` stays 1.
- R9: `wake_irq` clears one edge after `wake_irq_en` is sampled 0 and stays 0 while the enable is 0, even across wake events. Setting the enable back to 1 does not set it by itself; a new wake event is needed.
- R10: After any wake, `asleep` stays 0 for at least `ENTRY_DLY`+1 edges, because entry is evaluated again from the first ungated cycle.
- R11: During reset, `asleep` = 0, `clk_gate_en` = 1 and `wake_irq` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| sleep_en | input | 1 | Software permission to sleep |
| enh_en | input | 1 | Enhanced-feature switch, also required for sleep |
| wake_irq_en | input | 1 | Enable of the wake interrupt; writing 0 clears it |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| modem_in | input | MODEM_W | Asynchronous modem input pins |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_shift_empty | input | 1 | Transmit shift register idle |
| rx_fifo_empty | input | 1 | Receive FIFO holds no data |
| irq_pending | input | IRQ_W | Pending interrupt sources; bit THR_IDX is transmit-holding-empty |
| tx_fifo_wr | input | 1 | One-cycle host write strobe into the transmit FIFO |
| clk_gate_en | output | 1 | Enable for module and baud clock gating cells |
| asleep | output | 1 | Sleep status |
| wake_irq | output | 1 | Sticky wake interrupt |

## Verification
The assertions assume that `rx_line` and `modem_in` sit at their reset levels (line high, modem pins low) while reset is held. This keeps the edge detector from seeing a change on the first edge after release. They also assume that every other input is synchronous to `clk`, and that `tx_fifo_wr` is a single-cycle strobe. The bench changes every input only on the falling clock edge and holds the asynchronous pins at their reset levels across each reset. It always ends a wake by driving a strobe or a pin change, and never by dropping an entry condition, since a dropped condition does not wake the block.

// File: rtl/uslp_pkg.sv
package uslp_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ARM   = 2'd1,
    ST_SLEEP = 2'd2
  } sleep_state_t;

endpackage

// File: rtl/uslp_sync.sv
module uslp_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/uslp_edge.sv
module uslp_edge #(
  parameter int unsigned W        = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic         changed
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= d;
  end

  assign changed = |(d ^ prev_q);

endmodule

// File: rtl/uslp_fsm.sv
module uslp_fsm
  import uslp_pkg::*;
#(
  parameter int unsigned ENTRY_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_ok,
  input  logic wake_evt,
  output logic asleep,
  output logic gate_en
);

  localparam int unsigned CNT_W = $clog2(ENTRY_DLY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_DLY - 1);

  sleep_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic gate_q, gate_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        cnt_d = '0;
        if (idle_ok) state_d = ST_ARM;
      end
      ST_ARM: begin
        if (!idle_ok) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = ST_SLEEP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SLEEP: begin
        cnt_d = '0;
        if (wake_evt) state_d = ST_AWAKE;
      end
      default: begin
        state_d = ST_AWAKE;
        cnt_d   = '0;
      end
    endcase
    gate_d = (state_d != ST_SLEEP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
      gate_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gate_q  <= gate_d;
    end
  end

  assign asleep  = (state_q == ST_SLEEP);
  assign gate_en = gate_q;

endmodule

// File: rtl/uslp_wake_irq.sv
module uslp_wake_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic asleep,
  input  logic wake_evt,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 irq_q <= 1'b0;
    else if (!irq_en)           irq_q <= 1'b0;
    else if (asleep && wake_evt) irq_q <= 1'b1;
  end

  assign irq = irq_q;

endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
  parameter int unsigned MODEM_W     = 4,
  parameter int unsigned IRQ_W       = 6,
  parameter int unsigned THR_IDX     = 1,
  parameter int unsigned ENTRY_DLY   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_en,
  input  logic               enh_en,
  input  logic               wake_irq_en,
  input  logic               rx_line,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               tx_fifo_empty,
  input  logic               tx_shift_empty,
  input  logic               rx_fifo_empty,
  input  logic [IRQ_W-1:0]   irq_pending,
  input  logic               tx_fifo_wr,
  output logic               clk_gate_en,
  output logic               asleep,
  output logic               wake_irq
);

  localparam logic [IRQ_W-1:0] BLOCK_MASK = ~(IRQ_W'(1) << THR_IDX);

  logic               rx_s;
  logic [MODEM_W-1:0] modem_s;
  logic               rx_chg, modem_chg;
  logic               wake_evt, idle_ok;

  uslp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  uslp_sync #(.W(MODEM_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_modem_sync (
    .clk(clk), .rst_n(rst_n), .d(modem_in), .q(modem_s)
  );

  uslp_edge #(.W(1), .RST_VAL(1'b1)) u_rx_edge (
    .clk(clk), .rst_n(rst_n), .d(rx_s), .changed(rx_chg)
  );

  uslp_edge #(.W(MODEM_W), .RST_VAL('0)) u_modem_edge (
    .clk(clk), .rst_n(rst_n), .d(modem_s), .changed(modem_chg)
  );

  assign wake_evt = rx_chg | modem_chg | tx_fifo_wr;

  assign idle_ok = sleep_en & enh_en & rx_s &
                   tx_fifo_empty & tx_shift_empty & rx_fifo_empty &
                   ~|(irq_pending & BLOCK_MASK) & ~wake_evt;

  uslp_fsm #(.ENTRY_DLY(ENTRY_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_ok(idle_ok), .wake_evt(wake_evt),
    .asleep(asleep), .gate_en(clk_gate_en)
  );

  uslp_wake_irq u_wirq (
    .clk(clk), .rst_n(rst_n), .irq_en(wake_irq_en), .asleep(asleep),
    .wake_evt(wake_evt), .irq(wake_irq)
  );

endmodule

// File: rtl/uslp_checker.sv
module uslp_checker (
  input logic clk,
  input logic rst_n,
  input logic sleep_en,
  input logic enh_en,
  input logic wake_irq_en,
  input logic tx_fifo_empty,
  input logic tx_shift_empty,
  input logic rx_fifo_empty,
  input logic tx_fifo_wr,
  input logic clk_gate_en,
  input logic asleep,
  input logic wake_irq
);

  AST_SLEEP_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep_en && enh_en)); // R1

  AST_SLEEP_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(tx_fifo_empty && tx_shift_empty && rx_fifo_empty)); // R2

  AST_GATE_MATCHES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_en == !asleep); // R4

  AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(tx_fifo_empty && !tx_fifo_wr, 2)); // R5

  AST_WR_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && tx_fifo_wr |=> !asleep && clk_gate_en); // R6

  AST_IRQ_NEEDS_SLEEP_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(wake_irq_en && asleep)); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq && wake_irq_en |=> wake_irq); // R8

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_irq_en |=> !wake_irq); // R9

  AST_NO_QUICK_RESLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> !asleep); // R10

endmodule

bind uart_sleep_ctrl uslp_checker u_uslp_checker (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .enh_en(enh_en),
  .wake_irq_en(wake_irq_en), .tx_fifo_empty(tx_fifo_empty),
  .tx_shift_empty(tx_shift_empty), .rx_fifo_empty(rx_fifo_empty),
  .tx_fifo_wr(tx_fifo_wr), .clk_gate_en(clk_gate_en), .asleep(asleep),
  .wake_irq(wake_irq)
);

// File: tb/uart_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module uart_sleep_ctrl_bench;

  localparam int MODEM_W = 4;
  localparam int IRQ_W   = 6;
  localparam int DLY     = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_en, enh_en, wake_irq_en, rx_line;
  logic [MODEM_W-1:0] modem_in;
  logic tx_fifo_empty, tx_shift_empty, rx_fifo_empty, tx_fifo_wr;
  logic [IRQ_W-1:0] irq_pending;
  logic clk_gate_en, asleep, wake_irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  uart_sleep_ctrl #(.MODEM_W(MODEM_W), .IRQ_W(IRQ_W), .THR_IDX(1), .ENTRY_DLY(DLY)) u_uart_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .enh_en(enh_en),
    .wake_irq_en(wake_irq_en), .rx_line(rx_line), .modem_in(modem_in),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .rx_fifo_empty(rx_fifo_empty), .irq_pending(irq_pending),
    .tx_fifo_wr(tx_fifo_wr), .clk_gate_en(clk_gate_en), .asleep(asleep),
    .wake_irq(wake_irq)
  );

  // fields: [8] sleep_en [7] enh_en [6] rx_line [5] tx_fifo_empty
  // [4] tx_shift_empty [3] rx_fifo_empty [2] irq bit0 [1] irq bit1 (THR) [0] expected asleep
  localparam logic [8:0] VEC [10] = '{
    9'b1_1_1_1_1_1_0_0_1,
    9'b0_1_1_1_1_1_0_0_0,
    9'b1_0_1_1_1_1_0_0_0,
    9'b1_1_1_0_1_1_0_0_0,
    9'b1_1_1_1_0_1_0_0_0,
    9'b1_1_1_1_1_0_0_0_0,
    9'b1_1_1_1_1_1_1_0_0,
    9'b1_1_1_1_1_1_0_1_1,
    9'b1_1_0_1_1_1_0_0_0,
    9'b1_1_1_1_1_1_1_1_0
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_idle();
    sleep_en = 1; enh_en = 1; rx_line = 1;
    tx_fifo_empty = 1; tx_shift_empty = 1; rx_fifo_empty = 1;
    irq_pending = '0;
  endtask

  task automatic pulse_wr();
    tx_fifo_wr = 1; step(1); tx_fifo_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; sleep_en = 0; enh_en = 0; wake_irq_en = 0; rx_line = 1;
    modem_in = '0; tx_fifo_empty = 1; tx_shift_empty = 1; rx_fifo_empty = 1;
    irq_pending = '0; tx_fifo_wr = 0;
    step(3);
    check("R11", "asleep in reset", asleep, 1'b0);
    check("R11", "gate in reset", clk_gate_en, 1'b1);
    check("R11", "irq in reset", wake_irq, 1'b0);
    rst_n = 1;
    step(2);

    // table of idle-condition patterns
    for (int i = 0; i < 10; i++) begin
      logic [8:0] v;
      string req;
      v = VEC[i];
      sleep_en = v[8]; enh_en = v[7]; rx_line = v[6];
      tx_fifo_empty = v[5]; tx_shift_empty = v[4]; rx_fifo_empty = v[3];
      irq_pending = '0; irq_pending[0] = v[2]; irq_pending[1] = v[1];
      pulse_wr();
      step(12);
      if (v[2] || v[1])          req = "R3";
      else if (!(v[8] && v[7]))  req = "R1";
      else                       req = "R2";
      check(req, $sformatf("vector %0d asleep", i), asleep, v[0]);
      check("R4", $sformatf("vector %0d gate", i), clk_gate_en, !v[0]);
    end

    // entry timing
    set_idle(); tx_fifo_empty = 0; pulse_wr(); step(3);
    tx_fifo_empty = 1;
    step(DLY);
    check("R5", "not asleep one edge early", asleep, 1'b0);
    step(1);
    check("R5", "asleep after DLY+1 edges", asleep, 1'b1);

    // abort during the window
    pulse_wr(); tx_fifo_empty = 0; step(3);
    tx_fifo_empty = 1; step(2);
    tx_fifo_empty = 0; step(1);
    tx_fifo_empty = 1;
    step(DLY);
    check("R5", "window restarted after abort", asleep, 1'b0);
    step(1);
    check("R5", "asleep after restarted window", asleep, 1'b1);

    // host write wake and re-entry spacing
    pulse_wr();
    check("R6", "awake after write", asleep, 1'b0);
    check("R6", "gate on after write", clk_gate_en, 1'b1);
    step(DLY);
    check("R10", "no re-entry before full window", asleep, 1'b0);
    step(1);
    check("R10", "re-entry after full window", asleep, 1'b1);

    // receive-line edge wake
    rx_line = 0; step(2);
    check("R7", "still asleep during rx sync", asleep, 1'b1);
    step(1);
    check("R7", "awake after rx edge", asleep, 1'b0);
    rx_line = 1; step(12);
    check("R7", "asleep again with line idle", asleep, 1'b1);

    // modem change wake
    modem_in[2] = 1; step(2);
    check("R7", "still asleep during modem sync", asleep, 1'b1);
    step(1);
    check("R7", "awake after modem change", asleep, 1'b0);
    step(12);
    check("R7", "modem level does not block", asleep, 1'b1);

    // wake interrupt
    tx_fifo_empty = 0; pulse_wr(); step(2);
    wake_irq_en = 1; pulse_wr(); step(1);
    check("R8", "no irq for event while awake", wake_irq, 1'b0);
    tx_fifo_empty = 1; step(10);
    check("R8", "asleep before irq test", asleep, 1'b1);
    pulse_wr();
    check("R8", "irq set by wake", wake_irq, 1'b1);
    step(10);
    check("R8", "irq sticky", wake_irq, 1'b1);
    wake_irq_en = 0; step(1);
    check("R9", "irq cleared by enable low", wake_irq, 1'b0);
    step(10);
    pulse_wr();
    check("R9", "irq stays low with enable off", wake_irq, 1'b0);
    wake_irq_en = 1; step(3);
    check("R9", "re-enable alone does not set", wake_irq, 1'b0);
    step(10);
    pulse_wr();
    check("R9", "irq caught after re-enable", wake_irq, 1'b1);

    // reset while asleep
    step(10);
    check("R11", "asleep before reset", asleep, 1'b1);
    rst_n = 0; step(1);
    check("R11", "reset wakes", asleep, 1'b0);
    check("R11", "reset clears irq", wake_irq, 1'b0);
    check("R4", "gate on in reset", clk_gate_en, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule